// File: doc/BRIEF.md
# Error Detection and Handling Flag Processor

This block sits in the receive path of a serial digital video link, after the error-data packet of each field has been decoded and the local CRC and ancillary checksum comparisons are done. For each of three check classes (ancillary data, active picture, full field) it takes the five flags carried in from upstream, merges them with the local mismatch results and with locally raised internal-device errors, and produces the fifteen flags to be written into the outgoing packet. Flags that were detected upstream are recoded into their "already detected" form. A missing packet marks every class as having unknown error status.

Each outgoing flag can be forced high, forced low or passed through, but only in receive mode. In transmit mode every flag is cleared. The result is latched once per field on a field strobe. A sticky mode lets set flags accumulate until a read strobe. A sensitivity vector picks which flags raise an active-low interrupt and which advance a saturating errored-field counter. The counter is cleared by an explicit request, or by a read when auto-clear is on.

Top module: `edh_flag_engine`

## Requirements
- R1: Flag index is 5*class + kind, with class ancillary=0, active picture=1, full field=2, and kind EDH=0, EDA=1, IDH=2, IDA=3, UES=4. The same layout applies to `in_flags`, `mask_force`, `mask_value` and `out_flags`. For active picture and full field with a packet present, outgoing EDH equals the local CRC mismatch bit (`local_err[1]`, `local_err[2]`). Outgoing EDA is incoming EDA OR (incoming EDH AND `crc_valid`).
- R2: For the ancillary class, outgoing EDH equals the local checksum mismatch `local_err[0]`. With a packet present, outgoing EDA is incoming EDH OR incoming EDA.
- R3: In every class, outgoing IDH equals `user_idh[class]`. With a packet present, outgoing IDA is incoming IDH OR incoming IDA.
- R4: With `pkt_present` low, UES is set in all three classes. Active picture and full field EDH, EDA and IDA are 0. Ancillary EDA and IDA are 0, while ancillary EDH still follows `local_err[0]`. With a packet present, UES follows the incoming UES bit.
- R5: In receive mode (`rx_mode`=1), a flag whose `mask_force` bit is 1 takes its `mask_value` bit instead of the computed value.
- R6: In transmit mode (`rx_mode`=0), a field strobe makes all fifteen outgoing flags 0, whatever the masks and inputs.
- R7: `out_flags` change only in the cycle after `field_stb` or after a sticky-mode read. Outside sticky mode a strobe replaces them with the new field's flags.
- R8: With `sticky_en`=1, a field strobe ORs the new flags into the held ones. `rd_stb` clears them; a strobe in the same cycle as the read loads only the new flags.
- R9: On a field strobe, the counter adds one if any new flag is enabled by the sensitivity vector. It holds at its all-ones maximum (21 bits by default).
- R10: `cnt_clr`, or `rd_stb` with `auto_clr_en`=1, zeroes the counter on the next edge and overrides an increment in the same cycle.
- R11: `irq_n` goes low after a field strobe whose new flags hit the sensitivity vector, and returns high after `rd_stb`. A hit in the same cycle as the read keeps it low.
- R12: Sensitivity bit 4*class + kind covers kinds EDH..IDA. The single bit 12 covers UES for all three classes.
- R13: After reset, `out_flags` is 0, `irq_n` is 1 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_stb | input | 1 | One-cycle field boundary strobe; latches the new flags |
| rx_mode | input | 1 | 1 = receive (recode and mask), 0 = transmit (clear) |
| pkt_present | input | 1 | An error-data packet was received this field |
| crc_valid | input | 1 | The incoming CRC words were marked valid |
| in_flags | input | 15 | Incoming flags decoded from the packet |
| local_err | input | 3 | Local mismatch: [0] ancillary checksum, [1] active picture CRC, [2] full field CRC |
| user_idh | input | 3 | Internal device error raised locally, one per class |
| mask_force | input | 15 | 1 = override the flag |
| mask_value | input | 15 | Value used for overridden flags |
| sens | input | 13 | Interrupt and counter sensitivity |
| sticky_en | input | 1 | Accumulate flags until read |
| auto_clr_en | input | 1 | A read also clears the counter |
| cnt_clr | input | 1 | Clear the counter |
| rd_stb | input | 1 | Status read strobe |
| out_flags | output | 15 | Recoded flags for re-insertion |
| irq_n | output | 1 | Active-low interrupt |
| err_cnt | output | CNT_W (21) | Errored-field count |

## Verification
Every result is registered exactly once. Flags, interrupt and counter all reflect the inputs of a strobe or read cycle right after the next rising edge, one cycle later, and do not move otherwise. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares all three outputs at the following falling edge, one cycle after the stimulus. Checks that a flag is held or cleared are made in that same sample slot, before the next stimulus is applied.

// File: rtl/edh_flag_pkg.sv
package edh_flag_pkg;

    localparam int NUM_CLASS = 3;
    localparam int KINDS     = 5;
    localparam int NUM_FLAGS = NUM_CLASS * KINDS;
    localparam int SENS_PER  = 4;
    localparam int NUM_SENS  = NUM_CLASS * SENS_PER + 1;

    localparam int CLS_ANC = 0;
    localparam int CLS_AP  = 1;
    localparam int CLS_FF  = 2;

    localparam int K_EDH = 0;
    localparam int K_EDA = 1;
    localparam int K_IDH = 2;
    localparam int K_IDA = 3;
    localparam int K_UES = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [NUM_SENS-1:0]  sens_vec_t;

    // Spread the compact sensitivity word over the flag layout; one bit covers every UES.
    function automatic flag_vec_t sens_expand(input sens_vec_t s);
        flag_vec_t r;
        r = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int k = 0; k < SENS_PER; k++) begin
                r[c*KINDS + k] = s[c*SENS_PER + k];
            end
            r[c*KINDS + K_UES] = s[NUM_SENS-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/edh_recode.sv
module edh_recode
    import edh_flag_pkg::*;
(
    input  flag_vec_t              in_flags,
    input  logic                   pkt_present,
    input  logic                   crc_valid,
    input  logic [NUM_CLASS-1:0]   local_err,
    input  logic [NUM_CLASS-1:0]   user_idh,
    output flag_vec_t              raw_flags
);

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        localparam int B = c * KINDS;

        logic in_edh, in_eda, in_idh, in_ida, in_ues;
        assign in_edh = in_flags[B + K_EDH];
        assign in_eda = in_flags[B + K_EDA];
        assign in_idh = in_flags[B + K_IDH];
        assign in_ida = in_flags[B + K_IDA];
        assign in_ues = in_flags[B + K_UES];

        if (c == CLS_ANC) begin : g_anc
            // Checksum comparison stands on its own, so it reports even with no packet.
            assign raw_flags[B + K_EDH] = local_err[c];
            assign raw_flags[B + K_EDA] = pkt_present & (in_edh | in_eda);
        end else begin : g_crc
            assign raw_flags[B + K_EDH] = pkt_present & local_err[c];
            assign raw_flags[B + K_EDA] = pkt_present & (in_eda | (in_edh & crc_valid));
        end

        assign raw_flags[B + K_IDH] = user_idh[c];
        assign raw_flags[B + K_IDA] = pkt_present & (in_idh | in_ida);
        assign raw_flags[B + K_UES] = ~pkt_present | in_ues;
    end

endmodule

// File: rtl/edh_flag_gate.sv
module edh_flag_gate
    import edh_flag_pkg::*;
(
    input  logic       rx_mode,
    input  flag_vec_t  raw_flags,
    input  flag_vec_t  mask_force,
    input  flag_vec_t  mask_value,
    input  sens_vec_t  sens,
    output flag_vec_t  new_flags,
    output logic       sens_hit
);

    flag_vec_t masked;
    flag_vec_t sens_map;

    always_comb begin
        masked    = (raw_flags & ~mask_force) | (mask_value & mask_force);
        new_flags = rx_mode ? masked : '0;
        sens_map  = sens_expand(sens);
        sens_hit  = |(new_flags & sens_map);
    end

endmodule

// File: rtl/edh_err_counter.sv
module edh_err_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/edh_flag_engine.sv
module edh_flag_engine
    import edh_flag_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  field_stb,
    input  logic                  rx_mode,
    input  logic                  pkt_present,
    input  logic                  crc_valid,
    input  logic [14:0]           in_flags,
    input  logic [2:0]            local_err,
    input  logic [2:0]            user_idh,
    input  logic [14:0]           mask_force,
    input  logic [14:0]           mask_value,
    input  logic [12:0]           sens,
    input  logic                  sticky_en,
    input  logic                  auto_clr_en,
    input  logic                  cnt_clr,
    input  logic                  rd_stb,
    output logic [14:0]           out_flags,
    output logic                  irq_n,
    output logic [CNT_W-1:0]      err_cnt
);

    typedef struct packed {
        flag_vec_t flags;
        logic      irq;
    } state_t;

    flag_vec_t raw_flags;
    flag_vec_t new_flags;
    logic      sens_hit;
    logic      cnt_inc;
    logic      cnt_zero;
    state_t    st_d, st_q;

    edh_recode u_recode (
        .in_flags    (in_flags),
        .pkt_present (pkt_present),
        .crc_valid   (crc_valid),
        .local_err   (local_err),
        .user_idh    (user_idh),
        .raw_flags   (raw_flags)
    );

    edh_flag_gate u_gate (
        .rx_mode    (rx_mode),
        .raw_flags  (raw_flags),
        .mask_force (mask_force),
        .mask_value (mask_value),
        .sens       (sens),
        .new_flags  (new_flags),
        .sens_hit   (sens_hit)
    );

    always_comb begin
        st_d     = st_q;
        cnt_inc  = field_stb & sens_hit;
        cnt_zero = cnt_clr | (rd_stb & auto_clr_en);

        if (field_stb) begin
            if (!rx_mode) begin
                st_d.flags = '0;
            end else if (sticky_en && !rd_stb) begin
                st_d.flags = st_q.flags | new_flags;
            end else begin
                st_d.flags = new_flags;
            end
        end else if (rd_stb && sticky_en) begin
            st_d.flags = '0;
        end

        if (cnt_inc) begin
            st_d.irq = 1'b1;
        end else if (rd_stb) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    edh_err_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_zero),
        .inc   (cnt_inc),
        .count (err_cnt)
    );

    assign out_flags = st_q.flags;
    assign irq_n     = ~st_q.irq;

endmodule

// File: rtl/edh_flag_engine_chk.sv
module edh_flag_engine_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             field_stb,
    input logic             rx_mode,
    input logic             pkt_present,
    input logic [14:0]      mask_force,
    input logic             sticky_en,
    input logic             auto_clr_en,
    input logic             cnt_clr,
    input logic             rd_stb,
    input logic [14:0]      out_flags,
    input logic             irq_n,
    input logic [CNT_W-1:0] err_cnt
);

    AST_TX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (field_stb && !rx_mode) |=> (out_flags == 15'd0)); // R6

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_stb && !(rd_stb && sticky_en)) |=> $stable(out_flags)); // R7

    AST_STICKY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_stb && rd_stb && sticky_en) |=> (out_flags == 15'd0)); // R8

    AST_NOPKT_UES: assert property (@(posedge clk) disable iff (!rst_n)
        (field_stb && rx_mode && !pkt_present && !sticky_en && (mask_force[4] | mask_force[9] | mask_force[14]) == 1'b0)
        |=> (out_flags[4] && out_flags[9] && out_flags[14])); // R4

    AST_CNT_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !(rd_stb && auto_clr_en))
        |=> ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1))); // R9

    AST_CNT_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> (err_cnt <= $past(err_cnt))); // R9

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr || (rd_stb && auto_clr_en)) |=> (err_cnt == '0)); // R10

    AST_IRQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !field_stb) |=> irq_n); // R11

    AST_IRQ_NEEDS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_stb && irq_n) |=> irq_n); // R11

endmodule

bind edh_flag_engine edh_flag_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_stb   (field_stb),
    .rx_mode     (rx_mode),
    .pkt_present (pkt_present),
    .mask_force  (mask_force),
    .sticky_en   (sticky_en),
    .auto_clr_en (auto_clr_en),
    .cnt_clr     (cnt_clr),
    .rd_stb      (rd_stb),
    .out_flags   (out_flags),
    .irq_n       (irq_n),
    .err_cnt     (err_cnt)
);

// File: tb/edh_flag_engine_tb.sv
module edh_flag_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_stb = 0, rx_mode = 1, pkt_present = 1, crc_valid = 0;
    logic [14:0] in_flags = '0, mask_force = '0, mask_value = '0;
    logic [2:0]  local_err = '0, user_idh = '0;
    logic [12:0] sens = '1;
    logic sticky_en = 0, auto_clr_en = 0, cnt_clr = 0, rd_stb = 0;
    logic [14:0] out_flags;
    logic irq_n;
    logic [CW-1:0] err_cnt;

    int checks = 0;
    int errors = 0;
    logic [14:0] m_flags = '0;
    logic m_irq = 0;
    logic [CW-1:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edh_flag_engine #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .rx_mode(rx_mode),
        .pkt_present(pkt_present), .crc_valid(crc_valid), .in_flags(in_flags),
        .local_err(local_err), .user_idh(user_idh), .mask_force(mask_force),
        .mask_value(mask_value), .sens(sens), .sticky_en(sticky_en),
        .auto_clr_en(auto_clr_en), .cnt_clr(cnt_clr), .rd_stb(rd_stb),
        .out_flags(out_flags), .irq_n(irq_n), .err_cnt(err_cnt)
    );

    // Reference recoding written from the requirements.
    function automatic logic [14:0] ref_raw();
        logic [14:0] r;
        r = '0;
        for (int c = 0; c < 3; c++) begin
            int b;
            b = c * 5;
            if (c == 0) begin
                r[b]   = local_err[0];
                r[b+1] = pkt_present & (in_flags[b] | in_flags[b+1]);
            end else begin
                r[b]   = pkt_present & local_err[c];
                r[b+1] = pkt_present & (in_flags[b+1] | (in_flags[b] & crc_valid));
            end
            r[b+2] = user_idh[c];
            r[b+3] = pkt_present & (in_flags[b+2] | in_flags[b+3]);
            r[b+4] = !pkt_present | in_flags[b+4];
        end
        return r;
    endfunction

    function automatic logic [14:0] ref_new();
        logic [14:0] m;
        m = (ref_raw() & ~mask_force) | (mask_value & mask_force);
        return rx_mode ? m : 15'd0;
    endfunction

    function automatic logic ref_hit();
        logic [14:0] s;
        s = '0;
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 4; k++) s[c*5+k] = sens[c*4+k];
            s[c*5+4] = sens[12];
        end
        return |(ref_new() & s);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: advance model on the rising edge, compare at the falling edge.
    task automatic step();
        logic hit;
        @(posedge clk);
        hit = field_stb & ref_hit();
        if (field_stb) begin
            if (!rx_mode) m_flags = '0;
            else if (sticky_en && !rd_stb) m_flags = m_flags | ref_new();
            else m_flags = ref_new();
        end else if (rd_stb && sticky_en) begin
            m_flags = '0;
        end
        if (cnt_clr || (rd_stb && auto_clr_en)) m_cnt = '0;
        else if (hit && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
        if (hit) m_irq = 1'b1;
        else if (rd_stb) m_irq = 1'b0;
        @(negedge clk);
        chk("R7 flags", {17'd0, out_flags}, {17'd0, m_flags});
        chk("R9 count", {28'd0, err_cnt}, {28'd0, m_cnt});
        chk("R11 irq_n", {31'd0, irq_n}, {31'd0, ~m_irq});
    endtask

    task automatic field();
        field_stb = 1; step(); field_stb = 0;
    endtask

    task automatic read();
        rd_stb = 1; step(); rd_stb = 0;
    endtask

    task automatic quiet();
        in_flags = '0; local_err = '0; user_idh = '0; crc_valid = 0;
        pkt_present = 1; mask_force = '0; mask_value = '0; rx_mode = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 flags", {17'd0, out_flags}, 32'd0);
        chk("R13 irq_n", {31'd0, irq_n}, 32'd1);
        chk("R13 count", {28'd0, err_cnt}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        sens = '0;

        // R1 EDH recoded into EDA only when CRC valid; local CRC error -> EDH
        quiet(); in_flags[5] = 1; crc_valid = 1; field();
        chk("R1 ap eda valid", {31'd0, out_flags[6]}, 32'd1);
        crc_valid = 0; field();
        chk("R1 ap eda invalid", {31'd0, out_flags[6]}, 32'd0);
        quiet(); local_err[2] = 1; in_flags[11] = 1; field();
        chk("R1 ff edh/eda", {30'd0, out_flags[11:10]}, 32'd3);

        // R2 ancillary
        quiet(); in_flags[0] = 1; local_err[0] = 1; field();
        chk("R2 anc edh/eda", {30'd0, out_flags[1:0]}, 32'd3);

        // R3 IDH from user, IDA from incoming
        quiet(); in_flags[7] = 1; user_idh = 3'b100; field();
        chk("R3 ap ida", {31'd0, out_flags[8]}, 32'd1);
        chk("R3 ff idh", {31'd0, out_flags[12]}, 32'd1);

        // R4 packet missing
        quiet(); pkt_present = 0; in_flags = '1; local_err = '1; crc_valid = 1; field();
        chk("R4 no packet", {17'd0, out_flags}, 32'h4211);

        // R5 mask override
        quiet(); local_err = 3'b010; mask_force = 15'h0021; mask_value = 15'h0001; field();
        chk("R5 mask", {17'd0, out_flags}, 32'h0001);

        // R6 transmit clears even with forced ones
        quiet(); rx_mode = 0; mask_force = '1; mask_value = '1; in_flags = '1; field();
        chk("R6 tx", {17'd0, out_flags}, 32'd0);

        // R7 flags held without strobe
        quiet(); local_err = 3'b001; field();
        local_err = 3'b000; step(); step();
        chk("R7 hold", {17'd0, out_flags}, 32'h0001);

        // R8 sticky accumulate and read-clear
        sticky_en = 1;
        quiet(); local_err = 3'b010; field();
        quiet(); field();
        chk("R8 sticky keep", {31'd0, out_flags[5]}, 32'd1);
        read();
        chk("R8 sticky clear", {17'd0, out_flags}, 32'd0);
        sticky_en = 0;

        // R12 only UES sensitivity -> missing packet counts
        quiet(); cnt_clr = 1; step(); cnt_clr = 0;
        sens = 13'h1000; local_err = '1; field();
        chk("R12 no ues", {28'd0, err_cnt}, 32'd0);
        pkt_present = 0; field();
        chk("R12 ues counts", {28'd0, err_cnt}, 32'd1);
        chk("R11 irq low", {31'd0, irq_n}, 32'd0);
        rd_stb = 1; field(); rd_stb = 0;
        chk("R11 set wins", {31'd0, irq_n}, 32'd0);
        read();
        chk("R11 read clears", {31'd0, irq_n}, 32'd1);

        // R9 saturation
        for (int i = 0; i < 20; i++) field();
        chk("R9 saturate", {28'd0, err_cnt}, {28'd0, CMAX});

        // R10 clear priority and auto-clear
        cnt_clr = 1; field(); cnt_clr = 0;
        chk("R10 clear wins", {28'd0, err_cnt}, 32'd0);
        field(); field();
        auto_clr_en = 1; read(); auto_clr_en = 0;
        chk("R10 auto clear", {28'd0, err_cnt}, 32'd0);
        field(); read();
        chk("R10 read no auto", {28'd0, err_cnt}, 32'd1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            field_stb   = ($urandom % 4) == 0;
            rd_stb      = ($urandom % 8) == 0;
            cnt_clr     = ($urandom % 50) == 0;
            auto_clr_en = $urandom % 2;
            sticky_en   = ($urandom % 4) == 0;
            rx_mode     = ($urandom % 10) != 0;
            pkt_present = ($urandom % 5) != 0;
            crc_valid   = $urandom % 2;
            in_flags    = 15'($urandom);
            local_err   = 3'($urandom);
            user_idh    = 3'($urandom) & 3'($urandom);
            mask_force  = 15'($urandom) & 15'($urandom) & 15'($urandom);
            mask_value  = 15'($urandom);
            sens        = 13'($urandom) & 13'($urandom) & 13'($urandom);
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule